// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a word-wide NOR flash, modelled synchronously. Each clock cycle with `wr_valid` high carries one bus write (address and data word). The decoder steps through unlock-guarded command sequences. When a sequence completes, it issues a single-cycle start pulse for a word program, a sector erase, a block erase or a whole-array erase. The same pulse cycle presents the latched target address and, for a program, the latched data word. An external array timer drives `arr_busy` while an operation runs. It drives `susp_flag` while an erase is held in suspension. The decoder uses these two flags to pick the command set it accepts.

The decoder compares only the low address bits and the low data byte. Everything else in a command cycle is ignored. A write that breaks a sequence drops the decoder back to the read-array mode and the first step. A separate mode flag selects an identification read in place of array data. The write-protect pin, held low, blocks any operation whose target overlaps the topmost 8 kwords.

Sequence states: `SEQ_IDLE` (waiting for the first unlock), `SEQ_UNL1` (first unlock seen), `SEQ_UNL2` (second unlock seen, command byte expected), `SEQ_PDATA` (program word expected), `SEQ_ERA3` (erase setup seen, third unlock expected), `SEQ_ERA4` (fourth unlock seen), `SEQ_ERA5` (final erase byte expected).

Transitions:
- idle→unl1 on AAh@555h.
- unl1→unl2 on 55h@2AAh.
- unl2→pdata on A0h@555h.
- unl2→era3 on 80h@555h, not while suspended.
- unl2→idle on 90h@555h (ID entry, not while suspended) or F0h@555h (ID exit).
- era3→era4 on AAh@555h.
- era4→era5 on 55h@2AAh.
- pdata→idle and era5→idle on any write, issuing the request.
- Any other write in any state takes the decoder to idle and clears the ID mode.
- While `arr_busy` is high the state is frozen and sequence writes are ignored.

Top module: `fcd_top`

## Requirements
- R1: In the idle condition (`arr_busy`=0, `susp_flag`=0), the writes AAh@555h, 55h@2AAh, A0h@555h, then (A,D) make `prog_start` high for exactly the one cycle after the fourth write, with `tgt_addr`=A and `tgt_data`=D in that cycle.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 50h at address S raise `sect_erase_start` for one cycle with `tgt_addr`=S.
- R3: The same six-write prefix ending in 30h at address B raises `blk_erase_start`. Ending in 10h raises `chip_erase_start` only when address bits 10:0 equal 555h; 10h at any other address raises nothing.
- R4: Command cycles compare only address bits 10:0 and data bits 7:0. Address bits 20:11 and data bits 15:8 do not affect decoding.
- R5: A write that does not match the expected step aborts the sequence. The decoder returns to `SEQ_IDLE` and `id_mode` goes to 0, so a later write must begin again from the first unlock.
- R6: While `arr_busy`=1 after a program or chip-erase launch, every write is ignored. This includes F0h (the ID exit), B0h and full command sequences, and `id_mode` keeps its value.
- R7: While `arr_busy`=1 and `susp_flag`=0 after a sector or block erase launch, B0h at any address raises `susp_req` for one cycle. All other writes are ignored.
- R8: While `susp_flag`=1 and `arr_busy`=0, 30h at any address raises `resume_req`. A program sequence raises `prog_start` only if its target lies outside the suspended sector (bits 20:11) or block (bits 20:15). An erase setup (80h) aborts.
- R9: AAh@555h, 55h@2AAh, 90h@555h set `id_mode`=1. Either AAh@555h, 55h@2AAh, F0h@555h or a single F0h at any address clears it.
- R10: With `wp_n`=0, a request is dropped with no start pulse and the decoder returns to read mode in that cycle when it targets the top 8 kwords. Targeting means: a program or sector erase with address bits 20:13 all ones, a block erase with bits 20:15 all ones, or any chip erase. With `wp_n`=1 the same requests proceed.
- R11: Synchronous reset `rst`=1 clears every pulse, sets `id_mode`=0 and discards any partial sequence.
- R12: Start, suspend and resume pulses last one cycle, and no two are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | One bus write this cycle |
| wr_addr | input | 21 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| arr_busy | input | 1 | Array timer running an operation |
| susp_flag | input | 1 | Erase held in suspension |
| wp_n | input | 1 | Write protect, active low |
| prog_start | output | 1 | Word program request pulse |
| sect_erase_start | output | 1 | Sector erase request pulse |
| blk_erase_start | output | 1 | Block erase request pulse |
| chip_erase_start | output | 1 | Whole-array erase request pulse |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| tgt_addr | output | 21 | Address latched at the last launch |
| tgt_data | output | 16 | Data latched at the last program launch |
| id_mode | output | 1 | 1 = identification read, 0 = array read |

## Verification
A wrong sequence state shows up at the ports as a start pulse that appears where none was expected, or that goes missing. This becomes visible one cycle after the final write of the next sequence, so every scenario finishes its sequence and then inspects the pulse vector. Some errors show up only later. A stale record of which operation is running appears as a wrongly accepted or refused suspend on the next B0h write. A stale suspended-region record appears as a program that is accepted or refused on the wrong side of a sector or block boundary. For this reason the suspend scenarios probe targets just inside and just outside the region. The `id_mode` output shows the effect of an abort or exit in the cycle after the write that caused it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_UNL1,
        SEQ_UNL2,
        SEQ_PDATA,
        SEQ_ERA3,
        SEQ_ERA4,
        SEQ_ERA5
    } seq_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_t;

    localparam logic [7:0] C_UNL1  = 8'hAA;
    localparam logic [7:0] C_UNL2  = 8'h55;
    localparam logic [7:0] C_PROG  = 8'hA0;
    localparam logic [7:0] C_ERASE = 8'h80;
    localparam logic [7:0] C_SECT  = 8'h50;
    localparam logic [7:0] C_BLK   = 8'h30;
    localparam logic [7:0] C_CHIP  = 8'h10;
    localparam logic [7:0] C_SUSP  = 8'hB0;
    localparam logic [7:0] C_RES   = 8'h30;
    localparam logic [7:0] C_IDIN  = 8'h90;
    localparam logic [7:0] C_IDOUT = 8'hF0;

    localparam logic [15:0] A_UNL1 = 16'h0555;
    localparam logic [15:0] A_UNL2 = 16'h02AA;

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
    import fcd_pkg::*;
#(
    parameter int CMD_BITS = 11
) (
    input  logic [CMD_BITS-1:0] cmd_addr,
    input  logic [7:0]          data_lo,
    output logic                at_a1,
    output logic                step_u1,
    output logic                step_u2
);
    logic at_a2;

    always_comb begin
        at_a1   = (cmd_addr == A_UNL1[CMD_BITS-1:0]);
        at_a2   = (cmd_addr == A_UNL2[CMD_BITS-1:0]);
        step_u1 = at_a1 && (data_lo == C_UNL1);
        step_u2 = at_a2 && (data_lo == C_UNL2);
    end
endmodule

// File: rtl/fcd_region_guard.sv
module fcd_region_guard
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15,
    parameter int PROT_LSB = 13
) (
    input  op_t                      op,
    input  logic [ADDR_W-SECT_LSB-1:0] tgt_hi,
    input  logic                     wp_n,
    input  logic                     in_susp,
    input  logic [ADDR_W-SECT_LSB-1:0] sus_hi,
    input  logic                     sus_blk,
    output logic                     reject
);
    localparam int UW   = ADDR_W - SECT_LSB;
    localparam int P_OF = PROT_LSB - SECT_LSB;
    localparam int B_OF = BLK_LSB - SECT_LSB;

    logic win_hit;
    logic same_region;

    always_comb begin
        unique case (op)
            OP_PROG, OP_SECT: win_hit = &tgt_hi[UW-1:P_OF];
            OP_BLK:           win_hit = &tgt_hi[UW-1:B_OF];
            OP_CHIP:          win_hit = 1'b1;
            default:          win_hit = 1'b0;
        endcase
        if (sus_blk)
            same_region = (tgt_hi[UW-1:B_OF] == sus_hi[UW-1:B_OF]);
        else
            same_region = (tgt_hi == sus_hi);
        reject = (!wp_n && win_hit) || (in_susp && op == OP_PROG && same_region);
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int PROT_LSB = 13
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       arr_busy,
    input  logic                       susp_flag,
    input  logic                       wp_n,
    input  logic                       at_a1,
    input  logic                       step_u1,
    input  logic                       step_u2,
    input  logic                       reject,
    output op_t                        req_op,
    output logic                       in_susp,
    output logic [ADDR_W-SECT_LSB-1:0] sus_hi,
    output logic                       sus_blk,
    output logic                       prog_start,
    output logic                       sect_erase_start,
    output logic                       blk_erase_start,
    output logic                       chip_erase_start,
    output logic                       susp_req,
    output logic                       resume_req,
    output logic [ADDR_W-1:0]          tgt_addr,
    output logic [DATA_W-1:0]          tgt_data,
    output logic                       id_mode
);
    seq_t st, st_nxt;
    logic id_nxt, do_susp, do_res, launch, erase_run;
    logic [7:0] lo;

    assign lo      = wr_data[7:0];
    assign in_susp = susp_flag && !arr_busy;
    assign launch  = (req_op != OP_NONE) && !reject;

    always_comb begin
        st_nxt  = st;
        id_nxt  = id_mode;
        req_op  = OP_NONE;
        do_susp = 1'b0;
        do_res  = 1'b0;
        if (wr_valid) begin
            if (arr_busy) begin
                do_susp = !susp_flag && erase_run && (lo == C_SUSP);
            end else begin
                st_nxt = SEQ_IDLE;
                unique case (st)
                    SEQ_IDLE: begin
                        if (step_u1) st_nxt = SEQ_UNL1;
                        else if (susp_flag && lo == C_RES) do_res = 1'b1;
                        else id_nxt = 1'b0;
                    end
                    SEQ_UNL1: begin
                        if (step_u2) st_nxt = SEQ_UNL2;
                        else id_nxt = 1'b0;
                    end
                    SEQ_UNL2: begin
                        if (at_a1 && lo == C_PROG) st_nxt = SEQ_PDATA;
                        else if (!susp_flag && at_a1 && lo == C_ERASE) st_nxt = SEQ_ERA3;
                        else if (!susp_flag && at_a1 && lo == C_IDIN) id_nxt = 1'b1;
                        else id_nxt = 1'b0;
                    end
                    SEQ_PDATA: begin
                        req_op = OP_PROG;
                        if (reject) id_nxt = 1'b0;
                    end
                    SEQ_ERA3: begin
                        if (step_u1) st_nxt = SEQ_ERA4;
                        else id_nxt = 1'b0;
                    end
                    SEQ_ERA4: begin
                        if (step_u2) st_nxt = SEQ_ERA5;
                        else id_nxt = 1'b0;
                    end
                    SEQ_ERA5: begin
                        if (lo == C_SECT) req_op = OP_SECT;
                        else if (lo == C_BLK) req_op = OP_BLK;
                        else if (lo == C_CHIP && at_a1) req_op = OP_CHIP;
                        if (req_op == OP_NONE || reject) id_nxt = 1'b0;
                    end
                    default: id_nxt = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SEQ_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_start       <= 1'b0;
            sect_erase_start <= 1'b0;
            blk_erase_start  <= 1'b0;
            chip_erase_start <= 1'b0;
            susp_req         <= 1'b0;
            resume_req       <= 1'b0;
            tgt_addr         <= '0;
            tgt_data         <= '0;
            id_mode          <= 1'b0;
            erase_run        <= 1'b0;
            sus_hi           <= '0;
            sus_blk          <= 1'b0;
        end else begin
            prog_start       <= launch && req_op == OP_PROG;
            sect_erase_start <= launch && req_op == OP_SECT;
            blk_erase_start  <= launch && req_op == OP_BLK;
            chip_erase_start <= launch && req_op == OP_CHIP;
            susp_req         <= do_susp;
            resume_req       <= do_res;
            id_mode          <= id_nxt;
            if (launch) begin
                tgt_addr  <= wr_addr;
                erase_run <= (req_op == OP_SECT) || (req_op == OP_BLK);
                if (req_op == OP_PROG) tgt_data <= wr_data;
                if (req_op == OP_SECT || req_op == OP_BLK) begin
                    sus_hi  <= wr_addr[ADDR_W-1:SECT_LSB];
                    sus_blk <= (req_op == OP_BLK);
                end
            end else if (do_res) begin
                erase_run <= 1'b1;
            end
        end
    end

    logic [5:0] pulses;
    assign pulses = {prog_start, sect_erase_start, blk_erase_start,
                     chip_erase_start, susp_req, resume_req};

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses)); // R12
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        arr_busy |=> !(prog_start || sect_erase_start || blk_erase_start || chip_erase_start || resume_req)); // R6
    AST_SUSP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        !(arr_busy && !susp_flag) |=> !susp_req); // R7
    AST_RESUME_ONLY_SUSP: assert property (@(posedge clk) disable iff (rst)
        !(susp_flag && !arr_busy) |=> !resume_req); // R8
    AST_PROT_PROG: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !arr_busy && st == SEQ_PDATA && !wp_n && (&wr_addr[ADDR_W-1:PROT_LSB]))
        |=> !prog_start); // R10
    AST_PROT_CHIP: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> !chip_erase_start); // R10
    AST_ID_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_busy |=> $stable(id_mode)); // R6
endmodule

// File: rtl/fcd_top.sv
module fcd_top
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int CMD_BITS = 11,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15,
    parameter int PROT_LSB = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arr_busy,
    input  logic              susp_flag,
    input  logic              wp_n,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic              susp_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              id_mode
);
    localparam int UW = ADDR_W - SECT_LSB;

    logic          at_a1, step_u1, step_u2, reject, in_susp, sus_blk;
    op_t           req_op;
    logic [UW-1:0] sus_hi;

    fcd_cmd_match #(.CMD_BITS(CMD_BITS)) match_i (
        .cmd_addr (wr_addr[CMD_BITS-1:0]),
        .data_lo  (wr_data[7:0]),
        .at_a1    (at_a1),
        .step_u1  (step_u1),
        .step_u2  (step_u2)
    );

    fcd_region_guard #(
        .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB), .PROT_LSB(PROT_LSB)
    ) guard_i (
        .op      (req_op),
        .tgt_hi  (wr_addr[ADDR_W-1:SECT_LSB]),
        .wp_n    (wp_n),
        .in_susp (in_susp),
        .sus_hi  (sus_hi),
        .sus_blk (sus_blk),
        .reject  (reject)
    );

    fcd_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .PROT_LSB(PROT_LSB)
    ) fsm_i (
        .clk              (clk),
        .rst              (rst),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .arr_busy         (arr_busy),
        .susp_flag        (susp_flag),
        .wp_n             (wp_n),
        .at_a1            (at_a1),
        .step_u1          (step_u1),
        .step_u2          (step_u2),
        .reject           (reject),
        .req_op           (req_op),
        .in_susp          (in_susp),
        .sus_hi           (sus_hi),
        .sus_blk          (sus_blk),
        .prog_start       (prog_start),
        .sect_erase_start (sect_erase_start),
        .blk_erase_start  (blk_erase_start),
        .chip_erase_start (chip_erase_start),
        .susp_req         (susp_req),
        .resume_req       (resume_req),
        .tgt_addr         (tgt_addr),
        .tgt_data         (tgt_data),
        .id_mode          (id_mode)
    );
endmodule

// File: tb/fcd_top_tb_top.sv
module fcd_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        arr_busy = 1'b0;
    logic        susp_flag = 1'b0;
    logic        wp_n = 1'b1;
    logic        prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
    logic        susp_req, resume_req, id_mode;
    logic [20:0] tgt_addr;
    logic [15:0] tgt_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] snap;

    localparam logic [5:0] P_NONE = 6'b000000;
    localparam logic [5:0] P_PROG = 6'b100000;
    localparam logic [5:0] P_SECT = 6'b010000;
    localparam logic [5:0] P_BLK  = 6'b001000;
    localparam logic [5:0] P_CHIP = 6'b000100;
    localparam logic [5:0] P_SUSP = 6'b000010;
    localparam logic [5:0] P_RES  = 6'b000001;

    always #5 clk = ~clk;

    fcd_top dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_busy(arr_busy), .susp_flag(susp_flag), .wp_n(wp_n),
        .prog_start(prog_start), .sect_erase_start(sect_erase_start),
        .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
        .susp_req(susp_req), .resume_req(resume_req),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .id_mode(id_mode)
    );

    function automatic logic [5:0] pulses();
        return {prog_start, sect_erase_start, blk_erase_start, chip_erase_start, susp_req, resume_req};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        snap = pulses();
    endtask

    task automatic unlock();
        wr(21'h000555, 16'h00AA);
        wr(21'h0002AA, 16'h0055);
    endtask

    task automatic prog_seq(input logic [20:0] a, input logic [15:0] d);
        unlock(); wr(21'h000555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase_seq(input logic [20:0] a, input logic [15:0] d);
        unlock(); wr(21'h000555, 16'h0080); unlock(); wr(a, d);
    endtask

    task automatic id_enter();
        unlock(); wr(21'h000555, 16'h0090);
    endtask

    task automatic t_reset();
        check("R11 pulses after reset", {26'd0, pulses()}, {26'd0, P_NONE});
        check("R11 id_mode after reset", {31'd0, id_mode}, 32'd0);
    endtask

    task automatic t_program();
        prog_seq(21'h012345, 16'hBEEF);
        check("R1 prog pulse", {26'd0, snap}, {26'd0, P_PROG});
        check("R1 tgt_addr", {11'd0, tgt_addr}, 32'h012345);
        check("R1 tgt_data", {16'd0, tgt_data}, 32'hBEEF);
        @(negedge clk);
        check("R12 pulse one cycle", {26'd0, pulses()}, {26'd0, P_NONE});
    endtask

    task automatic t_dontcare();
        wr(21'h1FFD55, 16'h12AA);
        wr(21'h00AAAA, 16'hFF55);
        wr(21'h0F8555, 16'h77A0);
        wr(21'h000100, 16'h4242);
        check("R4 upper bits ignored", {26'd0, snap}, {26'd0, P_PROG});
    endtask

    task automatic t_sector();
        erase_seq(21'h0ABCDE, 16'h0050);
        check("R2 sector pulse", {26'd0, snap}, {26'd0, P_SECT});
        check("R2 sector addr", {11'd0, tgt_addr}, 32'h0ABCDE);
    endtask

    task automatic t_block();
        erase_seq(21'h100000, 16'h0030);
        check("R3 block pulse", {26'd0, snap}, {26'd0, P_BLK});
        check("R3 block addr", {11'd0, tgt_addr}, 32'h100000);
    endtask

    task automatic t_chip();
        erase_seq(21'h000555, 16'h0010);
        check("R3 chip pulse", {26'd0, snap}, {26'd0, P_CHIP});
        erase_seq(21'h000123, 16'h0010);
        check("R3 chip wrong addr", {26'd0, snap}, {26'd0, P_NONE});
    endtask

    task automatic t_abort();
        unlock(); wr(21'h000555, 16'h0077);
        wr(21'h000555, 16'h00A0); wr(21'h000200, 16'h1111);
        check("R5 aborted program", {26'd0, snap}, {26'd0, P_NONE});
        id_enter();
        check("R9 id entry", {31'd0, id_mode}, 32'd1);
        wr(21'h000555, 16'h0033);
        check("R5 abort leaves id", {31'd0, id_mode}, 32'd0);
    endtask

    task automatic t_id();
        id_enter();
        unlock(); wr(21'h000555, 16'h00F0);
        check("R9 three-cycle exit", {31'd0, id_mode}, 32'd0);
        id_enter();
        wr(21'h007777, 16'h00F0);
        check("R9 single exit", {31'd0, id_mode}, 32'd0);
    endtask

    task automatic t_busy_prog();
        id_enter();
        prog_seq(21'h000400, 16'h5555);
        check("R1 prog in id mode", {26'd0, snap}, {26'd0, P_PROG});
        @(negedge clk); arr_busy = 1'b1;
        wr(21'h000000, 16'h00F0);
        check("R6 F0 ignored while busy", {31'd0, id_mode}, 32'd1);
        wr(21'h000000, 16'h00B0);
        check("R6 B0 ignored in program", {26'd0, snap}, {26'd0, P_NONE});
        prog_seq(21'h000401, 16'h6666);
        check("R6 sequence ignored", {26'd0, snap}, {26'd0, P_NONE});
        @(negedge clk); arr_busy = 1'b0;
        wr(21'h000000, 16'h00F0);
        check("R9 exit after busy", {31'd0, id_mode}, 32'd0);
    endtask

    task automatic t_busy_sector();
        erase_seq(21'h0A0800, 16'h0050);
        @(negedge clk); arr_busy = 1'b1;
        wr(21'h000555, 16'h0080);
        check("R7 other write ignored", {26'd0, snap}, {26'd0, P_NONE});
        wr(21'h001234, 16'h00B0);
        check("R7 suspend pulse", {26'd0, snap}, {26'd0, P_SUSP});
        @(negedge clk); arr_busy = 1'b0; susp_flag = 1'b1;
        prog_seq(21'h0A0855, 16'h1234);
        check("R8 same sector refused", {26'd0, snap}, {26'd0, P_NONE});
        prog_seq(21'h0A1000, 16'h4321);
        check("R8 other sector accepted", {26'd0, snap}, {26'd0, P_PROG});
        check("R8 suspended prog addr", {11'd0, tgt_addr}, 32'h0A1000);
        unlock(); wr(21'h000555, 16'h0080);
        unlock(); wr(21'h050000, 16'h0050);
        check("R8 erase setup aborts", {26'd0, snap}, {26'd0, P_NONE});
        wr(21'h004444, 16'h0030);
        check("R8 resume pulse", {26'd0, snap}, {26'd0, P_RES});
        @(negedge clk); susp_flag = 1'b0; arr_busy = 1'b1;
        wr(21'h000000, 16'h00B0);
        check("R7 suspend after resume", {26'd0, snap}, {26'd0, P_SUSP});
        @(negedge clk); arr_busy = 1'b0;
    endtask

    task automatic t_busy_block();
        erase_seq(21'h108000, 16'h0030);
        @(negedge clk); arr_busy = 1'b1;
        wr(21'h000000, 16'h00B0);
        @(negedge clk); arr_busy = 1'b0; susp_flag = 1'b1;
        prog_seq(21'h10F000, 16'h0001);
        check("R8 same block refused", {26'd0, snap}, {26'd0, P_NONE});
        prog_seq(21'h110000, 16'h0002);
        check("R8 other block accepted", {26'd0, snap}, {26'd0, P_PROG});
        @(negedge clk); susp_flag = 1'b0;
    endtask

    task automatic t_protect();
        @(negedge clk); wp_n = 1'b0;
        prog_seq(21'h1FE010, 16'hAAAA);
        check("R10 protected program", {26'd0, snap}, {26'd0, P_NONE});
        prog_seq(21'h1FDFFF, 16'hBBBB);
        check("R10 below window", {26'd0, snap}, {26'd0, P_PROG});
        erase_seq(21'h1FF800, 16'h0050);
        check("R10 protected sector", {26'd0, snap}, {26'd0, P_NONE});
        erase_seq(21'h1F8000, 16'h0030);
        check("R10 protected block", {26'd0, snap}, {26'd0, P_NONE});
        erase_seq(21'h000555, 16'h0010);
        check("R10 protected chip", {26'd0, snap}, {26'd0, P_NONE});
        @(negedge clk); wp_n = 1'b1;
        prog_seq(21'h1FE010, 16'hCCCC);
        check("R10 unprotected program", {26'd0, snap}, {26'd0, P_PROG});
    endtask

    task automatic t_reset_mid();
        id_enter();
        unlock();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 id cleared", {31'd0, id_mode}, 32'd0);
        wr(21'h000555, 16'h00A0); wr(21'h000300, 16'h9999);
        check("R11 partial sequence dropped", {26'd0, snap}, {26'd0, P_NONE});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_dontcare();
        t_sector();
        t_block();
        t_chip();
        t_abort();
        t_id();
        t_busy_prog();
        t_busy_sector();
        t_busy_block();
        t_protect();
        t_reset_mid();
        finish_run();
    end
endmodule